// File: doc/BRIEF.md
# Scrambling NRZI Word Serializer

This block turns 10-bit parallel words into a serial bit stream, one bit per bit-clock cycle. Exactly ten bit cycles are spent on each word, so the word rate is one tenth of the bit rate. The block raises `word_take` in the cycle whose closing edge captures `word_in`, and the word source uses that strobe to present its next word.

Each serial bit normally goes through a self-synchronising scrambler that divides the stream by x^9+x^4+1. The result then goes through an x+1 stage that converts NRZ to NRZI, so runs of ones become runs of transitions. A bypass control, latched once per word, sends the raw bits straight out instead. The registered serial data is forced low when the lock indication is low or when the data enable is low. A separate registered gate tells the output stage whether to drive the serial clock.

Top module: `nrzi_word_serializer`

## Requirements
- R1: While `rst` is high, `ser_data` and `ser_clk_gate` are 0. In the first cycle after `rst` falls, `word_take` is 1. The scrambler history and the NRZI state both start at zero.
- R2: `word_take` is high in exactly one cycle out of every ten. Its rising edge loads `word_in` into the shift register.
- R3: Bits leave least significant first. Bit k of a word loaded at edge E appears on `ser_data` after edge E+k+1, for k = 0..9. In bypass mode the value is the raw bit.
- R4: When scrambling, each scrambled bit s[n] is b[n] ^ s[n-4] ^ s[n-9], where b[n] is the raw serial bit.
- R5: When scrambling, the emitted bit y[n] is s[n] ^ y[n-1], and y is registered onto `ser_data` with the same one-edge delay as in R3.
- R6: `bypass_in` is sampled only on the edge that loads a word (`word_take` high). It applies to all ten bits of that word, and changes at other times have no effect.
- R7: The scrambler history and the NRZI state keep advancing during bypassed words. A scrambled word that follows bypassed words continues the same recurrence.
- R8: If `locked` is low in a cycle, `ser_data` is 0 after the next edge. Internal state still advances.
- R9: If `data_en` is low in a cycle, `ser_data` is 0 after the next edge. Internal state still advances.
- R10: `ser_clk_gate` equals the value `sclk_en` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | 10 | Parallel word, captured when `word_take` is high |
| bypass_in | input | 1 | 1 = raw serial bits, 0 = scrambled NRZI; latched per word |
| locked | input | 1 | Clock lock indication; 0 forces `ser_data` low |
| data_en | input | 1 | 0 forces `ser_data` low |
| sclk_en | input | 1 | Serial clock enable request |
| word_take | output | 1 | High in the cycle whose edge loads `word_in` |
| ser_data | output | 1 | Registered serial data |
| ser_clk_gate | output | 1 | Registered serial clock enable |

## Verification
Every serial result is due one edge after the cycle in which its raw bit sits at the head of the shift register. The gating by `locked` and `data_en` acts at that same edge, and `ser_clk_gate` lags `sclk_en` by one edge. The bench samples on the falling edge. At each falling edge it compares `ser_data` with a value it computed one cycle earlier from the word, bit position, mode and gate inputs of that cycle. It also drives the inputs for the next edge at that falling edge. Word loads are tracked with the bench's own position counter, which is checked against `word_take` every cycle, so a slip of the load point shows up as a data mismatch as well as a strobe mismatch.

// File: rtl/nrzi_word_serializer.sv
module nrzi_word_serializer #(
  parameter int WORD_W = 10,
  parameter int TAP_A  = 4,
  parameter int TAP_B  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              bypass_in,
  input  logic              locked,
  input  logic              data_en,
  input  logic              sclk_en,
  output logic              word_take,
  output logic              ser_data,
  output logic              ser_clk_gate
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic [TAP_B-1:0]  hist;
  logic              nz;
  logic              mode;
  logic              raw_bit;
  logic              scr_bit;
  logic              nrzi_bit;
  logic              pick;

  assign word_take = (cnt == LAST);
  assign raw_bit   = shreg[0];
  assign scr_bit   = raw_bit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
  assign nrzi_bit  = nz ^ scr_bit;
  assign pick      = mode ? raw_bit : nrzi_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= LAST;
      shreg        <= '0;
      hist         <= '0;
      nz           <= 1'b0;
      mode         <= 1'b0;
      ser_data     <= 1'b0;
      ser_clk_gate <= 1'b0;
    end else begin
      if (word_take) begin
        shreg <= word_in;
        cnt   <= '0;
        mode  <= bypass_in;
      end else begin
        shreg <= shreg >> 1;
        cnt   <= cnt + CNT_W'(1);
      end
      hist         <= {hist[TAP_B-2:0], scr_bit};
      nz           <= nrzi_bit;
      ser_data     <= (locked && data_en) ? pick : 1'b0;
      ser_clk_gate <= sclk_en;
    end
  end
endmodule

module nrzi_word_serializer_checks (
  input logic clk,
  input logic rst,
  input logic word_take,
  input logic locked,
  input logic data_en,
  input logic sclk_en,
  input logic ser_data,
  input logic ser_clk_gate,
  input logic mode,
  input logic raw_bit
);
  p_take_gap_r2: assert property (@(posedge clk) disable iff (rst)
    word_take |=> !word_take);
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !word_take |=> $stable(mode));
  p_bypass_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (mode && locked && data_en) |=> (ser_data == $past(raw_bit)));
  p_lock_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !ser_data);
  p_den_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !data_en |=> !ser_data);
  p_clk_on_r10: assert property (@(posedge clk) disable iff (rst)
    sclk_en |=> ser_clk_gate);
  p_clk_off_r10: assert property (@(posedge clk) disable iff (rst)
    !sclk_en |=> !ser_clk_gate);
endmodule

bind nrzi_word_serializer nrzi_word_serializer_checks u_chk (
  .clk(clk), .rst(rst), .word_take(word_take), .locked(locked),
  .data_en(data_en), .sclk_en(sclk_en), .ser_data(ser_data),
  .ser_clk_gate(ser_clk_gate), .mode(mode), .raw_bit(raw_bit)
);

// File: tb/sim_nrzi_word_serializer.sv
`timescale 1ns/1ps
module sim_nrzi_word_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] word_in = '0;
  logic       bypass_in = 1'b0;
  logic       locked = 1'b1;
  logic       data_en = 1'b1;
  logic       sclk_en = 1'b0;
  logic       word_take, ser_data, ser_clk_gate;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nrzi_word_serializer u0 (
    .clk(clk), .rst(rst), .word_in(word_in), .bypass_in(bypass_in),
    .locked(locked), .data_en(data_en), .sclk_en(sclk_en),
    .word_take(word_take), .ser_data(ser_data), .ser_clk_gate(ser_clk_gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  localparam int NWORDS = 2176;

  logic [8:0] mh;
  logic       my;
  logic [9:0] cur_word;
  logic       bmode;
  int         pos;
  int         wi;
  logic       exp_cur;
  string      exp_tag;
  logic       last_sclk;

  initial begin
    repeat (3) @(negedge clk);
    chk(ser_data == 1'b0, "R1 ser_data in reset", ser_data, 0);
    chk(ser_clk_gate == 1'b0, "R1 ser_clk_gate in reset", ser_clk_gate, 0);
    mh = '0; my = 1'b0; cur_word = '0; bmode = 1'b0; pos = 9; wi = 0;
    exp_cur = 1'b0; exp_tag = "R1"; last_sclk = 1'b0;
    rst = 1'b0;
    for (int iter = 0; iter < NWORDS * 10 + 12; iter++) begin
      int p;
      logic b, s, y;
      if (iter > 0) @(negedge clk);
      chk(ser_data == exp_cur, exp_tag, ser_data, exp_cur);
      chk(ser_clk_gate == last_sclk, "R10 clock gate lag", ser_clk_gate, last_sclk);
      if (iter == 0)
        chk(word_take == 1'b1, "R1 first cycle load", word_take, 1);
      else
        chk(word_take == (pos == 9), "R2 load strobe period", word_take, pos == 9);
      p = (wi < 1024) ? 0 : (wi < 2048) ? 1 : (wi < 2112) ? 2 : 3;
      sclk_en = (iter % 5) != 0;
      locked  = !(p == 3 && (iter % 7) == 3);
      data_en = !(p == 3 && (iter % 11) == 5);
      if (pos == 9) begin
        case (p)
          0: begin word_in = 10'(wi); bypass_in = 1'b1; end
          1: begin word_in = 10'((wi * 389) % 1024); bypass_in = 1'b0; end
          2: begin word_in = 10'((wi * 613 + 5) % 1024); bypass_in = wi[0]; end
          default: begin word_in = 10'((wi * 613 + 5) % 1024); bypass_in = 1'b0; end
        endcase
      end else if (p == 2) begin
        bypass_in = iter[0];
      end
      b = cur_word[pos];
      s = b ^ mh[3] ^ mh[8];
      y = my ^ s;
      exp_cur = (locked && data_en) ? (bmode ? b : y) : 1'b0;
      mh = {mh[7:0], s};
      my = y;
      case (p)
        0: exp_tag = "R3 bypass bit order";
        1: exp_tag = "R4/R5 scrambled NRZI bit";
        2: exp_tag = "R6/R7 per-word bypass";
        default: exp_tag = "R8/R9 output gating";
      endcase
      last_sclk = sclk_en;
      if (pos == 9) begin
        cur_word = word_in;
        bmode = bypass_in;
        pos = 0;
        wi++;
      end else begin
        pos++;
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule